// File: doc/BRIEF.md
# DMA Channel Microcode Sequencer

This block is the control engine of one DMA channel. Software places a small program of byte-coded instructions in an instruction memory and pulses `start` with the program's first address. The sequencer then reads the program one byte per cycle, rebuilds each variable-length instruction, and executes it. The channel configuration, source address and destination address are set by immediate moves. Transfers are counted by two nestable hardware loop counters. Each load or store becomes a request to an external data mover. The program can also stall on a peripheral request line or raise a numbered event.

The sequencer does not move data itself. For every load or store it presents an address, a direction, an element size and a burst/single flag, and it holds them until the data mover acknowledges. After each acknowledged request it advances the source or destination pointer by the configured element size. A final instruction stops the channel and marks it done. An unknown instruction or an unsupported configuration stops it with a fault.

Top module: `chan_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `mreq_valid` and `evt_valid` are all low.
- R2: A `start` pulse while idle begins fetching at `start_addr`, clears `done` and `fault`, and holds `busy` high until the program stops.
- R3: Opcode 8'hBC is a 6-byte move. Its second byte picks the target: 0 loads the source pointer, 1 loads the channel configuration, 2 loads the destination pointer. Bytes 3 to 6 form a 32-bit immediate, least significant byte first. Any other target value raises `fault`.
- R4: Opcode 8'h20 | (n<<1) is a 2-byte loop start for counter n (0 or 1). Its second byte is the iteration count minus one, so 1 to 256 iterations are possible.
- R5: Opcode 8'h38 | (n<<2) | t, with t equal to 2'b01 or 2'b11, is a 2-byte loop end for counter n. If counter n is nonzero, it is decremented and execution resumes at the loop end's own address minus the unsigned second byte. If counter n is zero, execution falls through. Two loops may nest.
- R6: Opcode 8'h04 | t is a 1-byte load and 8'h08 | t is a 1-byte store, with t equal to 2'b01 (single) or 2'b11 (burst). Each issues exactly one request: `mreq_write` is 0 with the source pointer for a load, and 1 with the destination pointer for a store. `mreq_burst` equals bit 1 of t. The request stays asserted and unchanged until `mreq_ack`.
- R7: Configuration bit 0 enables source increment and bits [2:1] hold the source size code (0, 1, 2 for 1, 2, 4 bytes). Bit 3 enables destination increment and bits [5:4] hold the destination size code. `mreq_size` carries the code. After an acknowledged load or store, the matching pointer advances by the element size when its increment bit is set.
- R8: A load or store with unequal size codes, or with size code 3, raises `fault` and issues no request.
- R9: Opcodes 8'h30 to 8'h33 form a 2-byte wait whose peripheral number is in bits [7:3] of the second byte. Execution stalls until that bit of `periph_req` is high. Other bits have no effect.
- R10: Opcode 8'h34 is a 2-byte event whose number is in bits [7:3] of the second byte. It drives `evt_valid` high for exactly one cycle with `evt_num` set to that number.
- R11: Opcode 8'h00 stops the channel: `busy` falls and `done` rises, and `fault` stays low.
- R12: Any other opcode byte raises `fault` and stops the channel. No later instruction runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken while idle |
| start_addr | input | AW | Program start address |
| imem_addr | output | AW | Instruction byte address |
| imem_rdata | input | 8 | Instruction byte at `imem_addr`, same cycle |
| periph_req | input | NPERIPH | Peripheral request lines |
| evt_valid | output | 1 | Event pulse |
| evt_num | output | 5 | Event number |
| mreq_valid | output | 1 | Data mover request |
| mreq_write | output | 1 | 0 load (source side), 1 store (destination side) |
| mreq_burst | output | 1 | Burst transfer type |
| mreq_size | output | 2 | Element size code |
| mreq_addr | output | DW | Request address |
| mreq_ack | input | 1 | Data mover accepts the request |
| busy | output | 1 | Program running |
| done | output | 1 | Program ended normally |
| fault | output | 1 | Program stopped on an error |

## Verification
Transfers are tried with a single counted loop, with two nested loops, with a one-pass loop, and with a 256-pass loop. These runs separate a wrong iteration-count bias, wrong jump-back targets and wrong counter selection. Word, halfword and byte element sizes are each combined with different increment settings, which shows whether the size and the increment flag are applied per side. Slow acknowledgements check that requests hold steady. A wait with decoy request lines shows the peripheral index is decoded from the right bits. Bad opcodes, bad move targets and mismatched sizes each stop the channel with a fault and nothing further issued.

// File: rtl/chseq_pkg.sv
package chseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2,
        ST_MEM   = 2'd3
    } seq_state_e;

    typedef enum logic [3:0] {
        K_BAD, K_MOV, K_LP, K_LPEND, K_LD, K_ST, K_WFP, K_SEV, K_END
    } ins_kind_e;

    localparam logic [7:0] TGT_SRC = 8'd0;
    localparam logic [7:0] TGT_CFG = 8'd1;
    localparam logic [7:0] TGT_DST = 8'd2;

    localparam logic [1:0] SZ_BAD = 2'd3;

endpackage

// File: rtl/chseq_decode.sv
module chseq_decode
    import chseq_pkg::*;
(
    input  logic [7:0] op_i,
    output ins_kind_e  kind_o,
    output logic [2:0] len_o,
    output logic       sel_o,
    output logic       burst_o
);

    always_comb begin
        kind_o  = K_BAD;
        len_o   = 3'd1;
        sel_o   = 1'b0;
        burst_o = 1'b0;
        casez (op_i)
            8'hBC: begin
                kind_o = K_MOV;
                len_o  = 3'd6;
            end
            8'b0010_00?0: begin
                kind_o = K_LP;
                len_o  = 3'd2;
                sel_o  = op_i[1];
            end
            8'b0011_1??1: begin
                kind_o  = K_LPEND;
                len_o   = 3'd2;
                sel_o   = op_i[2];
                burst_o = op_i[1];
            end
            8'b0000_01?1: begin
                kind_o  = K_LD;
                burst_o = op_i[1];
            end
            8'b0000_10?1: begin
                kind_o  = K_ST;
                burst_o = op_i[1];
            end
            8'b0011_00??: begin
                kind_o = K_WFP;
                len_o  = 3'd2;
            end
            8'h34: begin
                kind_o = K_SEV;
                len_o  = 3'd2;
            end
            8'h00: kind_o = K_END;
            default: kind_o = K_BAD;
        endcase
    end

endmodule

// File: rtl/chseq_loops.sv
module chseq_loops #(
    parameter int NLOOP = 2,
    parameter int CW    = 8,
    localparam int SELW = (NLOOP > 1) ? $clog2(NLOOP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en,
    input  logic                      dec_en,
    input  logic [SELW-1:0]           sel,
    input  logic [CW-1:0]             ld_val,
    output logic [NLOOP-1:0][CW-1:0]  cnt_o
);

    for (genvar g = 0; g < NLOOP; g++) begin : g_ctr
        logic [CW-1:0] cnt_d, cnt_q;
        logic          hit;

        assign hit = (sel == SELW'(g));

        always_comb begin
            cnt_d = cnt_q;
            if (ld_en && hit) begin
                cnt_d = ld_val;
            end else if (dec_en && hit) begin
                cnt_d = cnt_q - CW'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign cnt_o[g] = cnt_q;

        // a counter is never stepped below zero (R5)
        p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_en && hit) |-> (cnt_q != '0));
    end

endmodule

// File: rtl/chan_sequencer.sv
module chan_sequencer
    import chseq_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int NPERIPH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AW-1:0]      start_addr,
    output logic [AW-1:0]      imem_addr,
    input  logic [7:0]         imem_rdata,
    input  logic [NPERIPH-1:0] periph_req,
    output logic               evt_valid,
    output logic [4:0]         evt_num,
    output logic               mreq_valid,
    output logic               mreq_write,
    output logic               mreq_burst,
    output logic [1:0]         mreq_size,
    output logic [DW-1:0]      mreq_addr,
    input  logic               mreq_ack,
    output logic               busy,
    output logic               done,
    output logic               fault
);

    localparam int NLOOP = 2;
    localparam int CW    = 8;
    localparam int NARG  = 5;

    typedef struct packed {
        seq_state_e            st;
        logic [AW-1:0]         pc;
        logic [AW-1:0]         ipc;
        logic [2:0]            bidx;
        logic [7:0]            op;
        logic [NARG-1:0][7:0]  b;
        logic [5:0]            cfg;
        logic [DW-1:0]         src;
        logic [DW-1:0]         dst;
        logic                  evt_v;
        logic [4:0]            evt_n;
        logic                  done;
        logic                  fault;
        logic                  mwr;
        logic                  mburst;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    // decoder input: the fresh opcode byte on the first fetch cycle,
    // the held opcode otherwise
    logic [7:0] dec_op;
    ins_kind_e  kind;
    logic [2:0] ilen;
    logic       lsel;
    logic       lburst;

    assign dec_op = (r_q.st == ST_FETCH && r_q.bidx == 3'd0) ? imem_rdata : r_q.op;

    chseq_decode i_dec (
        .op_i    (dec_op),
        .kind_o  (kind),
        .len_o   (ilen),
        .sel_o   (lsel),
        .burst_o (lburst)
    );

    logic                     lp_ld, lp_dec;
    logic [NLOOP-1:0][CW-1:0] lp_cnt;

    chseq_loops #(.NLOOP(NLOOP), .CW(CW)) i_loops (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (lp_ld),
        .dec_en (lp_dec),
        .sel    (lsel),
        .ld_val (r_q.b[0]),
        .cnt_o  (lp_cnt)
    );

    logic [31:0]   imm;
    logic [31:0]   preq_ext;
    logic [4:0]    pidx;
    logic [DW-1:0] step;
    logic          size_ok;

    assign imm     = {r_q.b[4], r_q.b[3], r_q.b[2], r_q.b[1]};
    assign pidx    = r_q.b[0][7:3];
    assign step    = DW'(1) << r_q.cfg[2:1];
    assign size_ok = (r_q.cfg[2:1] == r_q.cfg[5:4]) && (r_q.cfg[2:1] != SZ_BAD);

    always_comb begin
        preq_ext = '0;
        preq_ext[NPERIPH-1:0] = periph_req;
    end

    always_comb begin
        r_d       = r_q;
        r_d.evt_v = 1'b0;
        lp_ld     = 1'b0;
        lp_dec    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_FETCH;
                    r_d.pc    = start_addr;
                    r_d.bidx  = 3'd0;
                    r_d.done  = 1'b0;
                    r_d.fault = 1'b0;
                end
            end
            ST_FETCH: begin
                r_d.pc = r_q.pc + AW'(1);
                if (r_q.bidx == 3'd0) begin
                    r_d.op  = imem_rdata;
                    r_d.ipc = r_q.pc;
                    if (kind == K_BAD) begin
                        r_d.st    = ST_IDLE;
                        r_d.fault = 1'b1;
                        r_d.pc    = r_q.pc;
                    end else if (ilen == 3'd1) begin
                        r_d.st = ST_EXEC;
                    end else begin
                        r_d.bidx = 3'd1;
                    end
                end else begin
                    r_d.b[3'(r_q.bidx - 3'd1)] = imem_rdata;
                    if (r_q.bidx == ilen - 3'd1) begin
                        r_d.st   = ST_EXEC;
                        r_d.bidx = 3'd0;
                    end else begin
                        r_d.bidx = r_q.bidx + 3'd1;
                    end
                end
            end
            ST_EXEC: begin
                r_d.st = ST_FETCH;
                case (kind)
                    K_MOV: begin
                        case (r_q.b[0])
                            TGT_SRC: r_d.src = imm[DW-1:0];
                            TGT_CFG: r_d.cfg = imm[5:0];
                            TGT_DST: r_d.dst = imm[DW-1:0];
                            default: begin
                                r_d.st    = ST_IDLE;
                                r_d.fault = 1'b1;
                            end
                        endcase
                    end
                    K_LP: lp_ld = 1'b1;
                    K_LPEND: begin
                        if (lp_cnt[lsel] != '0) begin
                            lp_dec = 1'b1;
                            r_d.pc = r_q.ipc - AW'(r_q.b[0]);
                        end
                    end
                    K_LD, K_ST: begin
                        if (size_ok) begin
                            r_d.st     = ST_MEM;
                            r_d.mwr    = (kind == K_ST);
                            r_d.mburst = lburst;
                        end else begin
                            r_d.st    = ST_IDLE;
                            r_d.fault = 1'b1;
                        end
                    end
                    K_WFP: begin
                        if (!preq_ext[pidx]) r_d.st = ST_EXEC;
                    end
                    K_SEV: begin
                        r_d.evt_v = 1'b1;
                        r_d.evt_n = pidx;
                    end
                    K_END: begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                    default: begin
                        r_d.st    = ST_IDLE;
                        r_d.fault = 1'b1;
                    end
                endcase
            end
            ST_MEM: begin
                if (mreq_ack) begin
                    r_d.st = ST_FETCH;
                    if (!r_q.mwr && r_q.cfg[0]) r_d.src = r_q.src + step;
                    if (r_q.mwr && r_q.cfg[3])  r_d.dst = r_q.dst + step;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign imem_addr  = r_q.pc;
    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign fault      = r_q.fault;
    assign evt_valid  = r_q.evt_v;
    assign evt_num    = r_q.evt_n;
    assign mreq_valid = (r_q.st == ST_MEM);
    assign mreq_write = r_q.mwr;
    assign mreq_burst = r_q.mburst;
    assign mreq_size  = r_q.cfg[2:1];
    assign mreq_addr  = r_q.mwr ? r_q.dst : r_q.src;

    // an unacknowledged request holds its fields (R6)
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ack) |=> (mreq_valid && $stable(mreq_addr)
                                       && $stable(mreq_write) && $stable(mreq_burst)));

    // a request only exists while running (R2)
    p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> busy);

    // event lasts one cycle (R10)
    p_evt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);

    // a normal end never coexists with a fault (R11)
    p_end_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // a fault stops the channel (R12)
    p_fault_stops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> !busy);

endmodule

// File: tb/test_chan_sequencer.sv
module test_chan_sequencer;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] imem_addr;
    logic [7:0]    imem_rdata;
    logic [NP-1:0] periph_req = '0;
    logic          evt_valid;
    logic [4:0]    evt_num;
    logic          mreq_valid, mreq_write, mreq_burst;
    logic [1:0]    mreq_size;
    logic [DW-1:0] mreq_addr;
    logic          mreq_ack = 1'b0;
    logic          busy, done, fault;

    always #5 clk = ~clk;

    chan_sequencer #(.AW(AW), .DW(DW), .NPERIPH(NP)) i_chan_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata), .periph_req(periph_req),
        .evt_valid(evt_valid), .evt_num(evt_num), .mreq_valid(mreq_valid),
        .mreq_write(mreq_write), .mreq_burst(mreq_burst), .mreq_size(mreq_size),
        .mreq_addr(mreq_addr), .mreq_ack(mreq_ack), .busy(busy), .done(done),
        .fault(fault)
    );

    logic [7:0] prog [0:255];
    assign imem_rdata = prog[imem_addr];

    int total = 0;
    int bad   = 0;
    int wp    = 0;
    bit finished = 0;

    logic [DW-1:0] rec_addr  [0:511];
    logic          rec_wr    [0:511];
    logic          rec_burst [0:511];
    logic [1:0]    rec_size  [0:511];
    int            nrec = 0;
    logic [4:0]    ev_log [0:31];
    int            nev = 0;
    int            ack_delay = 0;
    int            dly = 0;

    // data mover model and event logger, acting on falling edges
    always @(negedge clk) begin
        if (evt_valid && nev < 32) begin
            ev_log[nev] = evt_num;
            nev = nev + 1;
        end
        if (mreq_valid && !mreq_ack) begin
            if (dly < ack_delay) begin
                dly = dly + 1;
            end else begin
                dly = 0;
                if (nrec < 512) begin
                    rec_addr[nrec]  = mreq_addr;
                    rec_wr[nrec]    = mreq_write;
                    rec_burst[nrec] = mreq_burst;
                    rec_size[nrec]  = mreq_size;
                end
                nrec = nrec + 1;
                mreq_ack = 1'b1;
            end
        end else begin
            mreq_ack = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        chk(act == exp, tag, act, exp);
    endtask

    // program writers
    task automatic put(input logic [7:0] v);
        prog[wp[7:0]] = v;
        wp = wp + 1;
    endtask
    task automatic w_mov(input logic [7:0] tgt, input logic [31:0] v);
        put(8'hBC); put(tgt); put(v[7:0]); put(v[15:8]); put(v[23:16]); put(v[31:24]);
    endtask
    task automatic w_lp(input int n, input int iters);
        put(8'h20 | 8'(n << 1)); put(8'(iters - 1));
    endtask
    task automatic w_lpend(input int n, input bit burst, input int body);
        put(8'h38 | 8'(n << 2) | (burst ? 8'h03 : 8'h01)); put(8'(wp - 1 - body));
    endtask
    task automatic w_ld(input bit burst);  put(burst ? 8'h07 : 8'h05); endtask
    task automatic w_st(input bit burst);  put(burst ? 8'h0B : 8'h09); endtask
    task automatic w_wfp(input int p);     put(8'h31); put(8'(p << 3)); endtask
    task automatic w_sev(input int e);     put(8'h34); put(8'(e << 3)); endtask
    task automatic w_end();                put(8'h00); endtask

    function automatic logic [31:0] cfg(input bit si, input int ss, input bit di, input int ds);
        return 32'(si) | 32'(ss << 1) | 32'(di << 3) | 32'(ds << 4);
    endfunction

    task automatic run(input int addr, input string tag);
        int cyc;
        nrec = 0;
        nev = 0;
        dly = 0;
        @(negedge clk);
        start_addr = AW'(addr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 6000) begin
            @(negedge clk);
            cyc++;
        end
        chk(!busy, {tag, " program stopped in time"}, cyc, 6000);
    endtask

    task automatic t_reset();
        chk_eq("R1 busy", busy, 0);
        chk_eq("R1 done", done, 0);
        chk_eq("R1 fault", fault, 0);
        chk_eq("R1 mreq_valid", mreq_valid, 0);
        chk_eq("R1 evt_valid", evt_valid, 0);
    endtask

    task automatic t_word_loop();
        int body;
        wp = 8'h40;
        w_mov(1, cfg(1, 2, 1, 2));
        w_mov(0, 32'h0000_1000);
        w_mov(2, 32'h0000_2000);
        w_lp(0, 3);
        body = wp;
        w_ld(1);
        w_st(1);
        w_lpend(0, 1, body);
        w_sev(5);
        w_end();
        ack_delay = 3;
        run(8'h40, "R2");
        ack_delay = 0;
        chk_eq("R11 done", done, 1);
        chk_eq("R11 fault", fault, 0);
        chk_eq("R4 R5 request count", nrec, 6);
        chk_eq("R6 first load addr", rec_addr[0], 32'h1000);
        chk_eq("R6 first load dir", rec_wr[0], 0);
        chk_eq("R6 burst flag", rec_burst[0], 1);
        chk_eq("R7 size code", rec_size[0], 2);
        chk_eq("R6 first store addr", rec_addr[1], 32'h2000);
        chk_eq("R6 store dir", rec_wr[1], 1);
        chk_eq("R7 third load addr", rec_addr[4], 32'h1008);
        chk_eq("R7 third store addr", rec_addr[5], 32'h2008);
        chk_eq("R10 event count", nev, 1);
        chk_eq("R10 event number", ev_log[0], 5);
    endtask

    task automatic t_nested();
        int b0, b1;
        bit st_ok;
        wp = 0;
        w_mov(1, cfg(1, 0, 0, 0));
        w_mov(0, 32'h0000_0300);
        w_mov(2, 32'h0000_0500);
        w_lp(0, 2);
        b0 = wp;
        w_lp(1, 3);
        b1 = wp;
        w_ld(0);
        w_st(0);
        w_lpend(1, 0, b1);
        w_lpend(0, 0, b0);
        w_end();
        run(0, "R5");
        chk_eq("R5 nested request count", nrec, 12);
        chk_eq("R7 byte load 0", rec_addr[0], 32'h300);
        chk_eq("R7 byte load 5", rec_addr[10], 32'h305);
        chk_eq("R6 single flag", rec_burst[0], 0);
        st_ok = 1;
        for (int i = 1; i < 12; i += 2)
            if (rec_addr[i] != 32'h500 || rec_wr[i] != 1'b1) st_ok = 0;
        chk_eq("R7 fixed destination", st_ok, 1);
        chk_eq("R11 nested done", done, 1);
    endtask

    task automatic t_half_once();
        int body;
        wp = 8'h80;
        w_mov(1, cfg(1, 1, 1, 1));
        w_mov(0, 32'h1234_5678);
        w_mov(2, 32'hA000_0010);
        w_lp(1, 1);
        body = wp;
        w_ld(1);
        w_st(0);
        w_lpend(1, 1, body);
        w_ld(0);
        w_end();
        run(8'h80, "R3");
        chk_eq("R4 one pass count", nrec, 3);
        chk_eq("R3 immediate byte order", rec_addr[0], 32'h1234_5678);
        chk_eq("R3 destination immediate", rec_addr[1], 32'hA000_0010);
        chk_eq("R7 halfword step", rec_addr[2], 32'h1234_567A);
        chk_eq("R7 halfword code", rec_size[2], 1);
    endtask

    task automatic t_max_loop();
        int body;
        wp = 8'hC0;
        w_mov(1, cfg(1, 0, 1, 0));
        w_mov(0, 32'h0000_4000);
        w_lp(0, 256);
        body = wp;
        w_ld(1);
        w_lpend(0, 1, body);
        w_end();
        run(8'hC0, "R4");
        chk_eq("R4 256 passes", nrec, 256);
        chk_eq("R4 last address", rec_addr[255], 32'h40FF);
    endtask

    task automatic t_wait();
        wp = 8'h20;
        w_wfp(9);
        w_sev(3);
        w_end();
        nev = 0;
        @(negedge clk);
        periph_req = '0;
        periph_req[8]  = 1'b1;
        periph_req[10] = 1'b1;
        start_addr = 8'h20;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk_eq("R9 stalled busy", busy, 1);
        chk_eq("R9 no event while stalled", nev, 0);
        periph_req[9] = 1'b1;
        for (int i = 0; i < 50 && busy; i++) @(negedge clk);
        periph_req = '0;
        chk_eq("R9 resumed done", done, 1);
        chk_eq("R10 event after wait", nev, 1);
        chk_eq("R10 event num after wait", ev_log[0], 3);
    endtask

    task automatic t_bad_op();
        wp = 8'h60;
        w_sev(1);
        put(8'hFF);
        w_sev(2);
        w_end();
        run(8'h60, "R12");
        chk_eq("R12 fault raised", fault, 1);
        chk_eq("R12 no done", done, 0);
        chk_eq("R12 later instruction skipped", nev, 1);
        // restart clears the fault
        wp = 8'h70;
        w_end();
        run(8'h70, "R2");
        chk_eq("R2 fault cleared on start", fault, 0);
        chk_eq("R2 done after restart", done, 1);
    endtask

    task automatic t_size_mismatch();
        wp = 8'hA0;
        w_mov(1, cfg(1, 2, 1, 1));
        w_ld(0);
        w_end();
        run(8'hA0, "R8");
        chk_eq("R8 fault on unequal sizes", fault, 1);
        chk_eq("R8 no request", nrec, 0);
        wp = 8'hA0;
        w_mov(1, cfg(0, 3, 0, 3));
        w_st(0);
        w_end();
        run(8'hA0, "R8");
        chk_eq("R8 fault on size code 3", fault, 1);
        chk_eq("R8 no request code 3", nrec, 0);
    endtask

    task automatic t_bad_target();
        wp = 8'hE0;
        w_mov(3, 32'h0);
        w_end();
        run(8'hE0, "R3");
        chk_eq("R3 bad target fault", fault, 1);
        chk_eq("R3 bad target no done", done, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_loop();
        t_nested();
        t_half_once();
        t_max_loop();
        t_wait();
        t_bad_op();
        t_size_mismatch();
        t_bad_target();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule